// File: doc/BRIEF.md
# Banked data memory address mapper

This block sits between a small processor core and its data RAM. The core issues accesses with an 8-bit data address. The mapper turns each one into a 12-bit RAM address, or serves it from a small register file of its own. Plain addresses are placed in the bank that software selected. The top sixteen addresses form a register window.

Inside the window the mapper holds several registers: the general bank number with an interrupt-enable bit, a ROM bank value, and two pointer/bank pairs. Each pair feeds an indirect data port, and an access to that port reaches RAM through the pair. The accumulator and status locations are handed to the core through select strobes. The input-only locations and the reserved locations are mapped to the top page of RAM, whatever bank is selected. Writes to the input-only locations are dropped.

Requests arrive on a valid/ready stream and leave towards RAM on a second valid/ready stream. An access that needs RAM is complete only when RAM accepts it. The block holds no request: `req_ready` simply follows `ram_ready` for these accesses. Every other access completes in the cycle it is presented. The requester must hold its address, write flag and data stable while `req_valid` is high and `req_ready` is low.

Top module: `bank_mapper`

## Requirements
- R1: An address in 0x00–0xEF drives `ram_valid` high and `ram_addr` = {current general bank (4 bits), address}. `ram_write` equals `req_write` and `ram_wdata` equals `req_wdata`.
- R2: A write to 0xFB stores bits 3:0 as the general bank and bit 7 as the interrupt enable (output `irq_en`). A read of 0xFB returns {enable, 000, bank}.
- R3: A read of 0xF0–0xF3, and a read or write of 0xF8–0xF9, goes to RAM at 0xFF0 + low nibble, whatever the general bank holds.
- R4: A write to 0xF0–0xF3 completes with `req_ready` high. It raises no `ram_valid`, `acc_sel` or `stat_sel`, and changes no register.
- R5: An access to 0xF4 raises `acc_sel`, and an access to 0xF5 raises `stat_sel`, for reads and writes. Neither raises `ram_valid`, and both complete with `req_ready` high.
- R6: An access to 0xF6 goes to RAM at {bank register 0xFD[3:0], pointer 0xFC}. An access to 0xF7 goes to RAM at {0xFF[3:0], 0xFE}. Reads and writes both pass.
- R7: 0xFA is an 8-bit ROM bank register, readable at 0xFA and presented on `rom_bank`.
- R8: The index bank registers 0xFD and 0xFF keep only bits 3:0, and they read back with bits 7:4 zero. The pointers 0xFC and 0xFE keep all 8 bits.
- R9: After reset, the general bank, interrupt enable, ROM bank and all index pointers and banks read as zero.
- R10: For an access that goes to RAM, `req_ready` equals `ram_ready`, and `ram_valid` does not depend on `ram_ready`.
- R11: `reg_hit` is high only for accesses to 0xFA–0xFF, and these complete with `req_ready` high. `reg_rdata` is zero when `reg_hit` is low. A register write takes effect at the clock edge where it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access valid |
| req_ready | output | 1 | Access accepted this cycle |
| req_addr | input | 8 | Data address from the instruction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| ram_valid | output | 1 | RAM access request |
| ram_ready | input | 1 | RAM accepts the request |
| ram_addr | output | 12 | Banked RAM address |
| ram_write | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| acc_sel | output | 1 | Accumulator location selected |
| stat_sel | output | 1 | Status location selected |
| reg_hit | output | 1 | Access served by the window register file |
| reg_rdata | output | 8 | Read data from the window register file |
| rom_bank | output | 8 | ROM bank register value |
| irq_en | output | 1 | Interrupt enable bit |

## Verification
Plain addresses are tried under more than one general bank, so that a bank that is dropped or bits that are swapped show up in `ram_addr`. Window locations are tried both before and after a bank change, which separates the forced top page from the selected bank. The indirect ports are tried with two different pointer/bank pairs and with writes that carry junk upper bits, which exposes pairs that are crossed or bank bits that are kept too wide. Accesses are also made with RAM holding off and with writes to the input-only locations, which separates stalls and dropped writes from accesses that complete.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  // Coarse class of an access, decided from the address alone.
  typedef enum logic [2:0] {
    K_RAM,    // plain banked RAM
    K_INPUT,  // input-only window locations
    K_ACC,    // accumulator location
    K_STAT,   // status location
    K_IDX0,   // indirect port through pair 0
    K_IDX1,   // indirect port through pair 1
    K_RSVD,   // reserved window locations, top page of RAM
    K_REG     // mapper register file
  } acc_kind_e;

  // Register file select.
  typedef enum logic [2:0] {
    RS_NONE,
    RS_ROM,
    RS_GEN,
    RS_IX0P,
    RS_IX0B,
    RS_IX1P,
    RS_IX1B
  } reg_sel_e;

  // Low-nibble offsets inside the window; behaviour depends on them.
  localparam logic [3:0] OFS_ACC  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h5;
  localparam logic [3:0] OFS_IDX0 = 4'h6;
  localparam logic [3:0] OFS_IDX1 = 4'h7;
  localparam logic [3:0] OFS_RSV0 = 4'h8;
  localparam logic [3:0] OFS_RSV1 = 4'h9;
  localparam logic [3:0] OFS_ROM  = 4'hA;
  localparam logic [3:0] OFS_GEN  = 4'hB;
  localparam logic [3:0] OFS_IX0P = 4'hC;
  localparam logic [3:0] OFS_IX0B = 4'hD;
  localparam logic [3:0] OFS_IX1P = 4'hE;
  localparam logic [3:0] OFS_IX1B = 4'hF;

  localparam int IDX_N = 2;

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output reg_sel_e          reg_sel
);

  logic       in_window;
  logic [3:0] lo;

  assign in_window = &addr[ADDR_W-1:4];
  assign lo        = addr[3:0];

  always_comb begin
    kind    = K_RAM;
    reg_sel = RS_NONE;
    if (in_window) begin
      unique case (lo)
        OFS_ACC:            kind = K_ACC;
        OFS_STAT:           kind = K_STAT;
        OFS_IDX0:           kind = K_IDX0;
        OFS_IDX1:           kind = K_IDX1;
        OFS_RSV0, OFS_RSV1: kind = K_RSVD;
        OFS_ROM:  begin kind = K_REG; reg_sel = RS_ROM;  end
        OFS_GEN:  begin kind = K_REG; reg_sel = RS_GEN;  end
        OFS_IX0P: begin kind = K_REG; reg_sel = RS_IX0P; end
        OFS_IX0B: begin kind = K_REG; reg_sel = RS_IX0B; end
        OFS_IX1P: begin kind = K_REG; reg_sel = RS_IX1P; end
        OFS_IX1B: begin kind = K_REG; reg_sel = RS_IX1B; end
        default:            kind = K_INPUT;
      endcase
    end
  end

endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int ROMB_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  reg_sel_e                      sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [BANK_W-1:0]             gen_bank,
  output logic                          irq_en,
  output logic [ROMB_W-1:0]             rom_bank,
  output logic [IDX_N-1:0][ADDR_W-1:0]  ix_ptr,
  output logic [IDX_N-1:0][BANK_W-1:0]  ix_bank,
  output logic [DATA_W-1:0]             rd_data
);

  localparam int IE_BIT = DATA_W - 1;

  logic [BANK_W-1:0] gen_q;
  logic              ie_q;
  logic [ROMB_W-1:0] rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q <= '0;
      ie_q  <= 1'b0;
      rom_q <= '0;
    end else if (wr_en) begin
      if (sel == RS_GEN) begin
        gen_q <= wdata[BANK_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (sel == RS_ROM) rom_q <= wdata[ROMB_W-1:0];
    end
  end

  for (genvar i = 0; i < IDX_N; i++) begin : g_idx
    localparam reg_sel_e P_SEL = (i == 0) ? RS_IX0P : RS_IX1P;
    localparam reg_sel_e B_SEL = (i == 0) ? RS_IX0B : RS_IX1B;
    logic [ADDR_W-1:0] p_q;
    logic [BANK_W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= '0;
        b_q <= '0;
      end else if (wr_en) begin
        if (sel == P_SEL) p_q <= wdata[ADDR_W-1:0];
        if (sel == B_SEL) b_q <= wdata[BANK_W-1:0];
      end
    end
    assign ix_ptr[i]  = p_q;
    assign ix_bank[i] = b_q;
  end

  assign gen_bank = gen_q;
  assign irq_en   = ie_q;
  assign rom_bank = rom_q;

  always_comb begin
    rd_data = '0;
    unique case (sel)
      RS_ROM:  rd_data[ROMB_W-1:0] = rom_q;
      RS_GEN:  begin
        rd_data[BANK_W-1:0] = gen_q;
        rd_data[IE_BIT]     = ie_q;
      end
      RS_IX0P: rd_data[ADDR_W-1:0] = ix_ptr[0];
      RS_IX0B: rd_data[BANK_W-1:0] = ix_bank[0];
      RS_IX1P: rd_data[ADDR_W-1:0] = ix_ptr[1];
      RS_IX1B: rd_data[BANK_W-1:0] = ix_bank[1];
      default: rd_data = '0;
    endcase
  end

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == RS_GEN) |=> $stable(gen_bank) && $stable(irq_en));

  // R7
  rom_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_ROM) |=> rom_bank == $past(wdata[ROMB_W-1:0]));

  // R8
  ixb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == RS_IX0B) |=> ix_bank[0] == $past(wdata[BANK_W-1:0]));

endmodule

// File: rtl/mapper_route.sv
module mapper_route
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 4,
  localparam int RA_W  = ADDR_W + BANK_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  acc_kind_e                     kind,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          write,
  input  logic                          req_valid,
  input  logic                          ram_ready,
  input  logic [BANK_W-1:0]             gen_bank,
  input  logic [IDX_N-1:0][ADDR_W-1:0]  ix_ptr,
  input  logic [IDX_N-1:0][BANK_W-1:0]  ix_bank,
  output logic                          ram_valid,
  output logic [RA_W-1:0]               ram_addr,
  output logic                          req_ready,
  output logic                          acc_sel,
  output logic                          stat_sel,
  output logic                          reg_hit,
  output logic                          reg_wr_en
);

  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  logic needs_ram;

  always_comb begin
    needs_ram = 1'b0;
    ram_addr  = {gen_bank, addr};
    unique case (kind)
      K_RAM:   needs_ram = 1'b1;
      K_INPUT: begin
        needs_ram = !write;
        ram_addr  = {TOP_BANK, addr};
      end
      K_RSVD:  begin
        needs_ram = 1'b1;
        ram_addr  = {TOP_BANK, addr};
      end
      K_IDX0:  begin
        needs_ram = 1'b1;
        ram_addr  = {ix_bank[0], ix_ptr[0]};
      end
      K_IDX1:  begin
        needs_ram = 1'b1;
        ram_addr  = {ix_bank[1], ix_ptr[1]};
      end
      default: needs_ram = 1'b0;
    endcase
  end

  assign ram_valid = req_valid && needs_ram;
  assign req_ready = needs_ram ? ram_ready : 1'b1;
  assign acc_sel   = req_valid && (kind == K_ACC);
  assign stat_sel  = req_valid && (kind == K_STAT);
  assign reg_hit   = req_valid && (kind == K_REG);
  assign reg_wr_en = reg_hit && write;

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_valid, acc_sel, stat_sel, reg_hit}));

  // R10
  ram_ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid |-> (req_ready == ram_ready));

  // R3
  top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && (kind == K_INPUT || kind == K_RSVD)) |-> (&ram_addr[RA_W-1:ADDR_W]));

  // R11
  reg_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> req_ready && !ram_valid);

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int ROMB_W = 8,
  localparam int RA_W  = ADDR_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic [RA_W-1:0]   ram_addr,
  output logic              ram_write,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              acc_sel,
  output logic              stat_sel,
  output logic              reg_hit,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ROMB_W-1:0] rom_bank,
  output logic              irq_en
);

  acc_kind_e                     kind;
  reg_sel_e                      sel;
  logic                          reg_wr_en;
  logic [BANK_W-1:0]             gen_bank;
  logic [IDX_N-1:0][ADDR_W-1:0]  ix_ptr;
  logic [IDX_N-1:0][BANK_W-1:0]  ix_bank;
  logic [DATA_W-1:0]             rd_data;

  mapper_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (req_addr),
    .kind    (kind),
    .reg_sel (sel)
  );

  mapper_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .ROMB_W(ROMB_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .sel      (sel),
    .wdata    (req_wdata),
    .gen_bank (gen_bank),
    .irq_en   (irq_en),
    .rom_bank (rom_bank),
    .ix_ptr   (ix_ptr),
    .ix_bank  (ix_bank),
    .rd_data  (rd_data)
  );

  mapper_route #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .addr      (req_addr),
    .write     (req_write),
    .req_valid (req_valid),
    .ram_ready (ram_ready),
    .gen_bank  (gen_bank),
    .ix_ptr    (ix_ptr),
    .ix_bank   (ix_bank),
    .ram_valid (ram_valid),
    .ram_addr  (ram_addr),
    .req_ready (req_ready),
    .acc_sel   (acc_sel),
    .stat_sel  (stat_sel),
    .reg_hit   (reg_hit),
    .reg_wr_en (reg_wr_en)
  );

  assign ram_write = ram_valid && req_write;
  assign ram_wdata = req_wdata;
  assign reg_rdata = reg_hit ? rd_data : '0;

  // R4
  input_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (&req_addr[ADDR_W-1:4]) && req_addr[3:2] == 2'b00)
      |-> (!ram_valid && !acc_sel && !stat_sel && req_ready));

  // R1
  plain_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(&req_addr[ADDR_W-1:4])) |-> (ram_valid && ram_addr[ADDR_W-1:0] == req_addr));

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        ram_valid;
  logic        ram_ready = 1'b1;
  logic [11:0] ram_addr;
  logic        ram_write;
  logic [7:0]  ram_wdata;
  logic        acc_sel, stat_sel, reg_hit;
  logic [7:0]  reg_rdata;
  logic [7:0]  rom_bank;
  logic        irq_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
    .ram_write(ram_write), .ram_wdata(ram_wdata),
    .acc_sel(acc_sel), .stat_sel(stat_sel), .reg_hit(reg_hit),
    .reg_rdata(reg_rdata), .rom_bank(rom_bank), .irq_en(irq_en)
  );

  typedef struct {
    string       tag;
    logic        rv;
    logic [11:0] ra;
    logic        rw;
    logic [7:0]  wd;
    logic        rdy;
    logic        acc;
    logic        st;
    logic        hit;
    logic [7:0]  rd;
    logic [7:0]  rom;
    logic        ie;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // Bench model of the window registers
  logic [3:0] m_bank = '0;
  logic       m_ie   = 1'b0;
  logic [7:0] m_rom  = '0;
  logic [7:0] m_ixp [2] = '{8'h00, 8'h00};
  logic [3:0] m_ixb [2] = '{4'h0, 4'h0};

  task automatic access(input string tag, input logic [7:0] a, input logic wr,
                        input logic [7:0] d, input logic rr);
    exp_t e;
    logic win;
    logic [3:0] lo;
    @(posedge clk);
    #1;
    win = (a[7:4] == 4'hF);
    lo  = a[3:0];
    e.tag = tag;
    e.rv = 1'b0; e.ra = '0; e.acc = 1'b0; e.st = 1'b0; e.hit = 1'b0; e.rd = '0;
    e.wd = d; e.rom = m_rom; e.ie = m_ie;
    if (!win) begin
      e.rv = 1'b1; e.ra = {m_bank, a};
    end else if (lo <= 4'h3) begin
      e.rv = !wr; e.ra = {4'hF, a};
    end else if (lo == 4'h4) e.acc = 1'b1;
    else if (lo == 4'h5) e.st = 1'b1;
    else if (lo == 4'h6) begin e.rv = 1'b1; e.ra = {m_ixb[0], m_ixp[0]}; end
    else if (lo == 4'h7) begin e.rv = 1'b1; e.ra = {m_ixb[1], m_ixp[1]}; end
    else if (lo <= 4'h9) begin e.rv = 1'b1; e.ra = {4'hF, a}; end
    else begin
      e.hit = 1'b1;
      case (lo)
        4'hA: e.rd = m_rom;
        4'hB: e.rd = {m_ie, 3'b000, m_bank};
        4'hC: e.rd = m_ixp[0];
        4'hD: e.rd = {4'h0, m_ixb[0]};
        4'hE: e.rd = m_ixp[1];
        default: e.rd = {4'h0, m_ixb[1]};
      endcase
    end
    e.rw  = e.rv && wr;
    e.rdy = e.rv ? rr : 1'b1;
    exp_q.push_back(e);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d; ram_ready = rr;
    if (wr && e.hit) begin
      case (lo)
        4'hA: m_rom = d;
        4'hB: begin m_bank = d[3:0]; m_ie = d[7]; end
        4'hC: m_ixp[0] = d;
        4'hD: m_ixb[0] = d[3:0];
        4'hE: m_ixp[1] = d;
        default: m_ixb[1] = d[3:0];
      endcase
    end
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0; ram_ready = 1'b1;
  endtask

  task automatic fail_line(input string tag, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
  endtask

  // Monitor: outputs are combinational, sampled mid-cycle
  always @(negedge clk) begin
    if (req_valid && exp_q.size() > 0) begin
      exp_t e;
      int bad;
      e = exp_q.pop_front();
      checks++;
      bad = 0;
      if (ram_valid !== e.rv) begin fail_line(e.tag, "ram_valid", ram_valid, e.rv); bad = 1; end
      if (e.rv && ram_addr !== e.ra) begin fail_line(e.tag, "ram_addr", ram_addr, e.ra); bad = 1; end
      if (ram_write !== e.rw) begin fail_line(e.tag, "ram_write", ram_write, e.rw); bad = 1; end
      if (e.rw && ram_wdata !== e.wd) begin fail_line(e.tag, "ram_wdata", ram_wdata, e.wd); bad = 1; end
      if (req_ready !== e.rdy) begin fail_line(e.tag, "req_ready", req_ready, e.rdy); bad = 1; end
      if (acc_sel !== e.acc) begin fail_line(e.tag, "acc_sel", acc_sel, e.acc); bad = 1; end
      if (stat_sel !== e.st) begin fail_line(e.tag, "stat_sel", stat_sel, e.st); bad = 1; end
      if (reg_hit !== e.hit) begin fail_line(e.tag, "reg_hit", reg_hit, e.hit); bad = 1; end
      if (reg_rdata !== e.rd) begin fail_line(e.tag, "reg_rdata", reg_rdata, e.rd); bad = 1; end
      if (rom_bank !== e.rom) begin fail_line(e.tag, "rom_bank", rom_bank, e.rom); bad = 1; end
      if (irq_en !== e.ie) begin fail_line(e.tag, "irq_en", irq_en, e.ie); bad = 1; end
      if (bad != 0) errors = errors - bad + 1;
    end
  end

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state of every register, read through the window
    access("R9", 8'hFA, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hFB, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hFC, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hFD, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hFE, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hFF, 1'b0, 8'h00, 1'b1);
    // R1: bank 0 plain access, read and write
    access("R1", 8'h23, 1'b0, 8'h00, 1'b1);
    access("R1", 8'hEF, 1'b1, 8'h5A, 1'b1);
    // R2: select bank 5 with interrupt enable
    access("R2", 8'hFB, 1'b1, 8'hF5, 1'b1);
    access("R2", 8'hFB, 1'b0, 8'h00, 1'b1);
    access("R1", 8'h23, 1'b0, 8'h00, 1'b1);
    access("R1", 8'h80, 1'b1, 8'hC3, 1'b1);
    // R3: window pages ignore bank 5
    access("R3", 8'hF1, 1'b0, 8'h00, 1'b1);
    access("R3", 8'hF8, 1'b1, 8'h11, 1'b1);
    access("R3", 8'hF9, 1'b0, 8'h00, 1'b1);
    // R4: write to input-only is dropped; bank readback unchanged
    access("R4", 8'hF2, 1'b1, 8'hAA, 1'b0);
    access("R4", 8'hF0, 1'b1, 8'h0F, 1'b1);
    access("R4", 8'hFB, 1'b0, 8'h00, 1'b1);
    // R5: accumulator and status strobes, with RAM stalled
    access("R5", 8'hF4, 1'b1, 8'h77, 1'b0);
    access("R5", 8'hF5, 1'b0, 8'h00, 1'b0);
    // R8, R6: index pairs, junk upper bank bits
    access("R8", 8'hFC, 1'b1, 8'h9C, 1'b1);
    access("R8", 8'hFD, 1'b1, 8'hA3, 1'b1);
    access("R8", 8'hFE, 1'b1, 8'h41, 1'b1);
    access("R8", 8'hFF, 1'b1, 8'h5E, 1'b1);
    access("R8", 8'hFD, 1'b0, 8'h00, 1'b1);
    access("R8", 8'hFF, 1'b0, 8'h00, 1'b1);
    access("R8", 8'hFC, 1'b0, 8'h00, 1'b1);
    access("R6", 8'hF6, 1'b0, 8'h00, 1'b1);
    access("R6", 8'hF7, 1'b1, 8'h3D, 1'b1);
    // R7: ROM bank
    access("R7", 8'hFA, 1'b1, 8'hB6, 1'b1);
    access("R7", 8'hFA, 1'b0, 8'h00, 1'b1);
    // R10: RAM back-pressure on plain and indirect accesses
    access("R10", 8'h10, 1'b1, 8'h66, 1'b0);
    access("R10", 8'h10, 1'b1, 8'h66, 1'b1);
    access("R10", 8'hF6, 1'b0, 8'h00, 1'b0);
    // R11: register write accepted while RAM stalls; takes effect next cycle
    access("R11", 8'hFB, 1'b1, 8'h02, 1'b0);
    access("R11", 8'h44, 1'b0, 8'h00, 1'b1);
    access("R11", 8'hFB, 1'b0, 8'h00, 1'b1);
    idle();
    // R11: reg_rdata zero with no hit
    @(negedge clk);
    checks++;
    if (reg_hit !== 1'b0 || reg_rdata !== 8'h00) begin
      errors++;
      $display("FAIL R11 idle reg_rdata: actual=%0h expected=0", reg_rdata);
    end
    // R9: reset again clears everything
    @(posedge clk);
    #1 rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_bank = '0; m_ie = 1'b0; m_rom = '0;
    m_ixp[0] = '0; m_ixp[1] = '0; m_ixb[0] = '0; m_ixb[1] = '0;
    access("R9", 8'hFB, 1'b0, 8'h00, 1'b1);
    access("R9", 8'hF7, 1'b0, 8'h00, 1'b1);
    idle();
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule